// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the fault-confinement bookkeeping of one CAN node. It holds a transmit error counter and a receive error counter, and it moves a three-state machine between error-active, error-passive and bus-off as those counters cross fixed limits. It also raises a warning flag when either counter gets high. The error detector and the frame sequencer feed it one-cycle event pulses: a transmit error, a receive error, a frame sent cleanly and a frame received cleanly. It also watches the sampled bus level, qualified by a sample strobe, so that it can count its own way out of bus-off.

The states are ACTIVE (code 0), PASSIVE (code 1) and BUSOFF (code 2). The transitions are: ACTIVE to PASSIVE when either counter reaches 128. PASSIVE to ACTIVE when both counters are back below 128. PASSIVE to BUSOFF when the transmit counter passes 255. BUSOFF to ACTIVE when the recovery count completes. ACTIVE cannot reach BUSOFF in one step, because the transmit counter is below 128 there and a single error adds only 8. The state and both counters update on the same clock edge that takes the event. The warning flag and the error-frame polarity follow the registered values.

Top module: `can_fault_conf`

## Requirements
- R1: The state output is 0 (ACTIVE) exactly when the node is not in bus-off and both counters are below 128.
- R2: The state output is 1 (PASSIVE) when the node is not in bus-off and at least one counter is 128 or more.
- R3: The state output becomes 2 (BUSOFF) on the edge where the transmit counter would exceed 255. The receive counter never causes bus-off.
- R4: The warning output is 1 while either counter is 96 or more. It is 0 once both counters are below 96.
- R5: A transmit-error pulse adds 8 to the transmit counter and takes priority over a simultaneous transmit-success pulse. A transmit-success pulse alone subtracts 1, and a counter at 0 stays at 0.
- R6: A receive-error pulse adds 1 to the receive counter, saturating at 255. A receive-success pulse alone subtracts 1, and a counter at 0 stays at 0.
- R7: While in BUSOFF, all four event pulses have no effect on either counter.
- R8: In BUSOFF, each strobe with the bus bit at 1 (recessive) extends the current run. Eleven such strobes complete a run. Completing the 128th run returns the state to ACTIVE with both counters at 0, on the edge that takes that strobe.
- R9: A strobe with the bus bit at 0 (dominant) during recovery restarts the current run. Runs already completed are kept.
- R10: The error-frame polarity output is 0 (dominant) in ACTIVE and 1 (recessive) in PASSIVE and BUSOFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| tx_ok_i | input | 1 | Frame transmitted successfully |
| rx_ok_i | input | 1 | Frame received successfully |
| bit_strobe_i | input | 1 | Bus bit sample strobe |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | Confinement state: 0 active, 1 passive, 2 bus-off |
| warn_o | output | 1 | Error warning flag |
| err_frame_rec_o | output | 1 | Error-frame polarity, 1 = recessive |

## Verification
The bench walks each counter across the 96, 128 and 255 boundaries in both directions. An off-by-one compare would show up as a wrong state or a wrong warning level one event early or late. It drives the receive counter well past 255 to show that it saturates rather than wraps and that it never forces bus-off. In bus-off it sends events that a leaky enable would let change the counters. It breaks the final recovery run with a dominant bit, so a design that clears the completed-run count would stay in bus-off, and one that ignores dominant bits would leave bus-off too early.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_t;
endpackage

// File: rtl/can_fc_errcnt.sv
// Up/down error counter: +INC on error, -1 on success (floor 0),
// optional saturation at all-ones, synchronous clear, hold when disabled.
module can_fc_errcnt #(
    parameter int W   = 8,
    parameter int INC = 1,
    parameter bit SAT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         err,
    input  logic         ok,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W:0] INC_V = (W+1)'(INC);

    logic [W:0]   sum;
    logic [W-1:0] bumped;

    assign sum = {1'b0, cnt} + INC_V;

    generate
        if (SAT) begin : g_sat
            assign bumped = sum[W] ? {W{1'b1}} : sum[W-1:0];
        end else begin : g_wrap
            assign bumped = sum[W-1:0];
        end
    endgenerate

    always_comb begin
        cnt_nxt = cnt;
        if (clr)
            cnt_nxt = '0;
        else if (en && err)
            cnt_nxt = bumped;
        else if (en && ok && (cnt != '0))
            cnt_nxt = cnt - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/can_fc_recovery.sv
// Counts runs of RUN_LEN recessive samples while armed; a dominant sample
// restarts the current run only. done pulses with the completing strobe.
module can_fc_recovery #(
    parameter int RUN_LEN = 11,
    parameter int RUNS    = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic strobe,
    input  logic recessive,
    output logic done
);
    localparam int BW = $clog2(RUN_LEN);
    localparam int RW = $clog2(RUNS);

    logic [BW-1:0] bit_cnt;
    logic [RW-1:0] run_cnt;
    logic          bit_last;
    logic          run_last;

    assign bit_last = (bit_cnt == BW'(RUN_LEN - 1));
    assign run_last = (run_cnt == RW'(RUNS - 1));
    assign done     = armed && strobe && recessive && bit_last && run_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            run_cnt <= '0;
        end else if (!armed) begin
            bit_cnt <= '0;
            run_cnt <= '0;
        end else if (strobe) begin
            if (!recessive) begin
                bit_cnt <= '0;
            end else if (bit_last) begin
                bit_cnt <= '0;
                run_cnt <= run_cnt + RW'(1);
            end else begin
                bit_cnt <= bit_cnt + BW'(1);
            end
        end
    end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int TEC_W      = 9,
    parameter int REC_W      = 8,
    parameter int TX_ERR_INC = 8,
    parameter int WARN_AT    = 96,
    parameter int PASSIVE_AT = 128,
    parameter int BUSOFF_GT  = 255,
    parameter int RUN_LEN    = 11,
    parameter int RUNS       = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             bit_strobe_i,
    input  logic             bus_bit_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o,
    output logic [1:0]       state_o,
    output logic             warn_o,
    output logic             err_frame_rec_o
);
    import can_fc_pkg::*;

    localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_AT);
    localparam logic [TEC_W-1:0] TEC_PASV = TEC_W'(PASSIVE_AT);
    localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_GT);
    localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_AT);
    localparam logic [REC_W-1:0] REC_PASV = REC_W'(PASSIVE_AT);

    fc_state_t         state_q, state_d;
    logic [TEC_W-1:0]  tec_nxt;
    logic [REC_W-1:0]  rec_nxt;
    logic              cnt_en;
    logic              recovered;

    assign cnt_en = (state_q != FC_BUSOFF);

    can_fc_errcnt #(.W(TEC_W), .INC(TX_ERR_INC), .SAT(1'b0)) u_tec (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(recovered),
        .err(tx_err_i), .ok(tx_ok_i), .cnt(tec_o), .cnt_nxt(tec_nxt)
    );

    can_fc_errcnt #(.W(REC_W), .INC(1), .SAT(1'b1)) u_rec (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(recovered),
        .err(rx_err_i), .ok(rx_ok_i), .cnt(rec_o), .cnt_nxt(rec_nxt)
    );

    can_fc_recovery #(.RUN_LEN(RUN_LEN), .RUNS(RUNS)) u_recov (
        .clk(clk), .rst_n(rst_n), .armed(state_q == FC_BUSOFF),
        .strobe(bit_strobe_i), .recessive(bus_bit_i), .done(recovered)
    );

    // next-state logic, evaluated on the counters' next values
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE: begin
                if (tec_nxt > TEC_OFF)
                    state_d = FC_BUSOFF;
                else if (tec_nxt >= TEC_PASV || rec_nxt >= REC_PASV)
                    state_d = FC_PASSIVE;
            end
            FC_PASSIVE: begin
                if (tec_nxt > TEC_OFF)
                    state_d = FC_BUSOFF;
                else if (tec_nxt < TEC_PASV && rec_nxt < REC_PASV)
                    state_d = FC_ACTIVE;
            end
            FC_BUSOFF: begin
                if (recovered)
                    state_d = FC_ACTIVE;
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FC_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o         = state_q;
        warn_o          = (tec_o >= TEC_WARN) || (rec_o >= REC_WARN);
        err_frame_rec_o = (state_q != FC_ACTIVE);
    end
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_err_i,
    input logic [8:0] tec_o,
    input logic [7:0] rec_o,
    input logic [1:0] state_o
);
    AST_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> (tec_o < 9'd128 && rec_o < 8'd128)); // R1
    AST_PASSIVE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |-> ((tec_o >= 9'd128 || rec_o >= 8'd128) && tec_o <= 9'd255)); // R2
    AST_BUSOFF_TEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> (tec_o > 9'd255)); // R3
    AST_NO_DIRECT_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |=> (state_o != 2'd2)); // R3
    AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd2 && tx_err_i) |=> (tec_o == $past(tec_o) + 9'd8)); // R5
    AST_BUSOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |=> (state_o == 2'd0 || ($stable(tec_o) && $stable(rec_o)))); // R7
    AST_EXIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && $past(state_o) == 2'd2) |-> (tec_o == 9'd0 && rec_o == 8'd0)); // R8
endmodule

bind can_fault_conf can_fault_conf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i),
    .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o)
);

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0;
    logic       strobe = 1'b0, bus_bit = 1'b1;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] state;
    logic       warn, pol;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    can_fault_conf uut (
        .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err),
        .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .bit_strobe_i(strobe),
        .bus_bit_i(bus_bit), .tec_o(tec), .rec_o(rec), .state_o(state),
        .warn_o(warn), .err_frame_rec_o(pol)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ev(input bit te, input bit re, input bit to, input bit ro, input int n);
        for (int i = 0; i < n; i++) begin
            tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro;
            @(negedge clk);
            tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0;
        end
    endtask

    task automatic bits(input bit lvl, input int n);
        for (int i = 0; i < n; i++) begin
            bus_bit = lvl; strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0; bus_bit = 1'b1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset tec", tec, 0);
        chk("R1 reset rec", rec, 0);
        chk("R1 reset state", state, 0);
        chk("R4 reset warn", warn, 0);
        chk("R10 reset polarity", pol, 0);
    endtask

    task automatic t_tx_path();
        do_reset();
        ev(1, 0, 0, 0, 11);
        chk("R5 tec after 11 errors", tec, 88);
        chk("R4 warn below 96", warn, 0);
        ev(1, 0, 0, 0, 1);
        chk("R4 warn at 96", warn, 1);
        chk("R1 active at 96", state, 0);
        ev(1, 0, 0, 0, 4);
        chk("R2 passive at 128", state, 1);
        chk("R10 recessive in passive", pol, 1);
        ev(1, 0, 1, 0, 1);
        chk("R5 error wins over success", tec, 136);
        ev(0, 0, 1, 0, 9);
        chk("R5 tec decrement", tec, 127);
        chk("R1 back to active", state, 0);
        chk("R10 dominant in active", pol, 0);
        chk("R4 warn held at 127", warn, 1);
        ev(0, 0, 1, 0, 32);
        chk("R4 warn cleared at 95", warn, 0);
        ev(0, 0, 1, 0, 100);
        chk("R5 tec floor at 0", tec, 0);
    endtask

    task automatic t_rx_path();
        do_reset();
        ev(0, 1, 0, 0, 96);
        chk("R4 warn from rec", warn, 1);
        ev(0, 1, 0, 0, 32);
        chk("R2 passive from rec", state, 1);
        ev(0, 1, 0, 0, 200);
        chk("R6 rec saturates", rec, 255);
        chk("R3 rec cannot bus-off", state, 1);
        ev(0, 0, 0, 1, 128);
        chk("R6 rec decrement", rec, 127);
        chk("R1 active after rec drop", state, 0);
        ev(0, 0, 0, 1, 200);
        chk("R6 rec floor at 0", rec, 0);
    endtask

    task automatic t_busoff();
        do_reset();
        ev(1, 0, 0, 0, 31);
        chk("R2 passive at 248", state, 1);
        ev(1, 0, 0, 0, 1);
        chk("R3 enter bus-off", state, 2);
        chk("R3 tec past 255", tec, 256);
        chk("R10 recessive in bus-off", pol, 1);
        ev(1, 1, 0, 0, 3);
        ev(0, 0, 1, 1, 3);
        chk("R7 tec frozen", tec, 256);
        chk("R7 rec frozen", rec, 0);
        bits(1, 127 * 11);
        chk("R8 still bus-off after 127 runs", state, 2);
        bits(1, 10);
        bits(0, 1);
        bits(1, 10);
        chk("R9 dominant restarts run", state, 2);
        bits(1, 1);
        chk("R9 completed runs kept", state, 0);
        chk("R8 tec cleared", tec, 0);
        chk("R8 rec cleared", rec, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_tx_path();
        t_rx_path();
        t_busoff();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule